// File: doc/BRIEF.md
# Double-Buffered Crosspoint Configuration Register

This block holds the connection map of a crosspoint switch with 33 inputs and 17 outputs. Every output owns two 7-bit configuration words: a staging word that the host writes one output at a time, and an active word that steers the switch. A single commit strobe copies every staging word into its active word in the same clock edge. This lets a complete new map be prepared ahead of time and then switched in at once.

The active words drive a per-output multiplexer with an enable. A readback port returns the active word of one output on a separate bus. A synchronous active-low reset turns off every output and leaves the staging words and the active select fields unchanged. A chip-select input gates write, commit and readback. It never gates reset.

All control strobes are active-low and are sampled on the rising edge of `clk`. A strobe acts on every edge at which it is low.

Top module: `xbar_cfg_top`

## Requirements
- R1: Each of the 17 outputs has a 7-bit staging word and a 7-bit active word. Bits [5:0] hold the input number (0 to 32) and bit [6] is the enable. Output addresses 0 to 16 are binary, with `addr[4]` as the most significant bit.
- R2: Output o is connected when its active enable bit is 1 and its active select field is 32 or less. A connected output has `out_en[o]`=1 and `sig_out[o]` = `sig_in[select]`. An unconnected output has `out_en[o]`=0 and `sig_out[o]`=0, and this includes a select field from 33 to 63.
- R3: At an edge where `cs_n`=0 and `we_n`=0, `wdata` is stored into the staging word of output `addr` only. If `addr` is 17 to 31, nothing is stored.
- R4: At an edge where `cs_n`=0 and `upd_n`=0, all 17 active words take their staging values, whatever `addr` holds. The outputs change only at such an edge.
- R5: If a write and a commit fall on the same edge, the active word takes the staging value from before that write, and the staging word takes the new data.
- R6: At an edge where `rst_n`=0, every active enable bit is cleared and `rdata` is cleared. The active select fields and all staging words keep their values, and a commit on that edge is ignored.
- R7: While `cs_n`=1, write, commit and readback have no effect. Reset still works.
- R8: At an edge where `cs_n`=0 and `rd_n`=0, `rdata` takes the active word of output `addr`, or zero if `addr` is 17 to 31. At any other edge, `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; disables all outputs |
| cs_n | input | 1 | Active-low chip select for write, commit and readback |
| we_n | input | 1 | Active-low staging write strobe |
| upd_n | input | 1 | Active-low global commit strobe |
| rd_n | input | 1 | Active-low readback strobe |
| addr | input | 5 | Output address for write and readback |
| wdata | input | 7 | Configuration word to write: {enable, select[5:0]} |
| rdata | output | 7 | Active word read back, registered |
| sig_in | input | 33 | Switch inputs (33 x DATA_W, DATA_W=1) |
| sig_out | output | 17 | Switch outputs (17 x DATA_W) |
| out_en | output | 17 | Per-output connected flag |

## Verification
The bench writes a full map and checks that the outputs stay off until the commit. A design that let staging leak through would change the outputs early. It commits in the same edge as a write, where a wrong bypass would load the new word instead of the old one. It then resets and reads back: a design that cleared whole words or the staging rank would lose the select fields. The bench also drives writes, commits and reads while chip select is high. It writes and reads addresses past the last output, where a decoder that wraps or truncates the address would corrupt a real row. It sets a select field above 32, which a plain multiplexer would still route to an output.

// File: rtl/xbar_cfg_pkg.sv
// Shared constants and the configuration word layout for the crosspoint
// configuration register. Assumes the select field is no wider than 6 bits.
package xbar_cfg_pkg;
    parameter int unsigned XB_N_IN   = 33;
    parameter int unsigned XB_N_OUT  = 17;
    parameter int unsigned XB_ADDR_W = 5;
    parameter int unsigned XB_SEL_W  = 6;
    localparam int unsigned XB_WORD_W = XB_SEL_W + 1;

    // Enable in the top bit, input select below it.
    typedef struct packed {
        logic                en;
        logic [XB_SEL_W-1:0] sel;
    } xb_word_t;
endpackage

// File: rtl/xbar_ctrl_decode.sv
// Qualifies the active-low control strobes with chip select and checks the
// output address range. Purely combinational; assumes the strobes are already
// synchronous to the system clock.
module xbar_ctrl_decode #(
    parameter int unsigned N_OUT  = xbar_cfg_pkg::XB_N_OUT,
    parameter int unsigned ADDR_W = xbar_cfg_pkg::XB_ADDR_W
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              upd_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_go,
    output logic              upd_go,
    output logic              rd_go,
    output logic              addr_ok
);
    localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(N_OUT - 1);

    // Gate each request by chip select; a write also needs a valid row.
    always_comb begin
        addr_ok = (addr <= LAST_ROW);
        wr_go   = !cs_n && !we_n && addr_ok;
        upd_go  = !cs_n && !upd_n;
        rd_go   = !cs_n && !rd_n;
    end
endmodule

// File: rtl/xbar_stage_bank.sv
// Staging rank: one configuration word per output, written one row at a time.
// The staging rank is intentionally not reset; software programs every row
// before the first commit.
module xbar_stage_bank
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned N_OUT  = XB_N_OUT,
    parameter int unsigned ADDR_W = XB_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_go,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  xb_word_t              wr_word,
    output xb_word_t [N_OUT-1:0]  stage_q
);
    // Store the write word into the addressed row only.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_OUT; i++) begin
            if (wr_go && (wr_addr == ADDR_W'(i))) begin
                stage_q[i] <= wr_word;
            end
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_row_chk
        AST_STAGE_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_go && (wr_addr == ADDR_W'(g))) |=> (stage_q[g] == $past(stage_q[g]))); // R3
    end
endmodule

// File: rtl/xbar_active_bank.sv
// Active rank: takes all staging words together on a commit, loses only its
// enable bits on reset, and serves registered readback of one row.
module xbar_active_bank
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned N_OUT  = XB_N_OUT,
    parameter int unsigned ADDR_W = XB_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_go,
    input  xb_word_t [N_OUT-1:0]  stage_q,
    input  logic                  rd_go,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  addr_ok,
    output xb_word_t [N_OUT-1:0]  act_q,
    output logic [XB_WORD_W-1:0]  rdata
);
    logic [N_OUT-1:0] en_vec;

    // Commit, reset of the enable bits, and readback capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_OUT; i++) begin
                act_q[i].en <= 1'b0;
            end
            rdata <= '0;
        end else begin
            if (upd_go) begin
                act_q <= stage_q;
            end
            if (rd_go) begin
                rdata <= addr_ok ? act_q[rd_addr] : '0;
            end
        end
    end

    // Gather the enable bits for checking.
    always_comb begin
        for (int i = 0; i < N_OUT; i++) begin
            en_vec[i] = act_q[i].en;
        end
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_go |=> (act_q == $past(act_q))); // R4
    AST_ACT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_go |=> (act_q == $past(stage_q))); // R5
    AST_RST_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_vec == '0)); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rdata)); // R8
endmodule

// File: rtl/xbar_switch.sv
// Switch matrix model: each output is a multiplexer over all inputs with an
// enable. A select field past the last input leaves the output off.
module xbar_switch
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned N_IN   = XB_N_IN,
    parameter int unsigned N_OUT  = XB_N_OUT,
    parameter int unsigned DATA_W = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  xb_word_t [N_OUT-1:0]              act_q,
    input  logic [N_IN-1:0][DATA_W-1:0]       sig_in,
    output logic [N_OUT-1:0][DATA_W-1:0]      sig_out,
    output logic [N_OUT-1:0]                  out_en
);
    localparam logic [XB_SEL_W-1:0] LAST_SEL = XB_SEL_W'(N_IN - 1);

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        // Route the selected input when enabled and in range, else drive zero.
        always_comb begin
            out_en[g]  = act_q[g].en && (act_q[g].sel <= LAST_SEL);
            sig_out[g] = out_en[g] ? sig_in[act_q[g].sel] : '0;
        end

        AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[g] |-> (sig_out[g] == '0)); // R2
        AST_EN_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[g] |-> act_q[g].en); // R2
    end
endmodule

// File: rtl/xbar_cfg_top.sv
// Top of the double-buffered crosspoint configuration register: control
// decode, staging rank, active rank with readback, and the switch model.
// Assumes all control inputs are synchronous to clk.
module xbar_cfg_top
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned N_IN   = XB_N_IN,
    parameter int unsigned N_OUT  = XB_N_OUT,
    parameter int unsigned ADDR_W = XB_ADDR_W,
    parameter int unsigned DATA_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          we_n,
    input  logic                          upd_n,
    input  logic                          rd_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [XB_WORD_W-1:0]          wdata,
    output logic [XB_WORD_W-1:0]          rdata,
    input  logic [N_IN-1:0][DATA_W-1:0]   sig_in,
    output logic [N_OUT-1:0][DATA_W-1:0]  sig_out,
    output logic [N_OUT-1:0]              out_en
);
    logic                  wr_go;
    logic                  upd_go;
    logic                  rd_go;
    logic                  addr_ok;
    xb_word_t [N_OUT-1:0]  stage_q;
    xb_word_t [N_OUT-1:0]  act_q;

    xbar_ctrl_decode #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_dec (
        .cs_n(cs_n), .we_n(we_n), .upd_n(upd_n), .rd_n(rd_n), .addr(addr),
        .wr_go(wr_go), .upd_go(upd_go), .rd_go(rd_go), .addr_ok(addr_ok)
    );

    xbar_stage_bank #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(addr),
        .wr_word(xb_word_t'(wdata)), .stage_q(stage_q)
    );

    xbar_active_bank #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_active (
        .clk(clk), .rst_n(rst_n), .upd_go(upd_go), .stage_q(stage_q),
        .rd_go(rd_go), .rd_addr(addr), .addr_ok(addr_ok),
        .act_q(act_q), .rdata(rdata)
    );

    xbar_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W)) u_sw (
        .clk(clk), .rst_n(rst_n), .act_q(act_q), .sig_in(sig_in),
        .sig_out(sig_out), .out_en(out_en)
    );

    AST_CS_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (stage_q == $past(stage_q))); // R7
    AST_CS_KEEPS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (act_q == $past(act_q))); // R7
endmodule

// File: tb/xbar_cfg_top_tb.sv
// Directed bench for xbar_cfg_top with a reference model kept in the bench.
module xbar_cfg_top_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, we_n = 1'b1, upd_n = 1'b1, rd_n = 1'b1;
    logic [4:0]        addr = '0;
    logic [6:0]        wdata = '0;
    logic [6:0]        rdata;
    logic [32:0][0:0]  sig_in = '0;
    logic [16:0][0:0]  sig_out;
    logic [16:0]       out_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [6:0] m_stage [17];
    logic [6:0] m_act   [17];

    always #2.5 clk = ~clk;

    xbar_cfg_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .upd_n(upd_n),
        .rd_n(rd_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .sig_in(sig_in), .sig_out(sig_out), .out_en(out_en)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic m_reset();
        for (int i = 0; i < 17; i++) m_act[i][6] = 1'b0;
    endtask

    task automatic m_commit();
        for (int i = 0; i < 17; i++) m_act[i] = m_stage[i];
    endtask

    task automatic wr(input logic [4:0] a, input logic [6:0] d);
        cs_n = 0; we_n = 0; addr = a; wdata = d;
        cyc();
        cs_n = 1; we_n = 1;
        if (a < 17) m_stage[a] = d;
    endtask

    task automatic commit();
        cs_n = 0; upd_n = 0; addr = 5'd30;
        cyc();
        cs_n = 1; upd_n = 1;
        m_commit();
    endtask

    task automatic rd(input logic [4:0] a, input logic [6:0] exp, input string req);
        cs_n = 0; rd_n = 0; addr = a;
        cyc();
        cs_n = 1; rd_n = 1;
        chk(req, $sformatf("readback row %0d", a), 32'(rdata), 32'(exp));
    endtask

    // R2: compare every output against the bench model.
    task automatic chk_outs(input string req);
        for (int o = 0; o < 17; o++) begin
            logic en;
            logic v;
            en = m_act[o][6] && (m_act[o][5:0] <= 6'd32);
            v  = en ? sig_in[m_act[o][5:0]] : 1'b0;
            chk(req, $sformatf("out_en[%0d]", o), 32'(out_en[o]), 32'(en));
            chk(req, $sformatf("sig_out[%0d]", o), 32'(sig_out[o]), 32'(v));
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        m_reset();
        chk("R6", "out_en after reset", 32'(out_en), 32'h0);
        chk("R6", "sig_out after reset", 32'(sig_out), 32'h0);
        chk("R6", "rdata after reset", 32'(rdata), 32'h0);
    endtask

    task automatic t_load_and_commit();
        for (int i = 0; i < 17; i++) begin
            logic [6:0] w;
            w = {1'b1, 6'((i * 5 + 3) % 33)};
            if (i == 4) w = 7'h07;
            wr(5'(i), w);
        end
        chk("R4", "outputs off before commit", 32'(out_en), 32'h0);
        commit();
        sig_in = 33'h1_5A5A_C3C3;
        #1 chk_outs("R1 R4");
        sig_in = 33'h0_A5A5_3C3C;
        #1 chk_outs("R2");
    endtask

    task automatic t_readback();
        for (int i = 0; i < 17; i++) rd(5'(i), m_act[i], "R8");
        rd(5'd20, 7'h00, "R8");
        rd(5'd9, m_act[9], "R8");
        addr = 5'd2;
        cyc();
        chk("R8", "rdata held without read", 32'(rdata), 32'(m_act[9]));
    endtask

    task automatic t_bad_addr();
        wr(5'd25, 7'h45);
        wr(5'd17, 7'h41);
        commit();
        #1 chk_outs("R3");
        rd(5'd17, 7'h00, "R3");
    endtask

    task automatic t_wide_sel();
        wr(5'd2, 7'h68);
        commit();
        chk("R2", "out_en[2] with select 40", 32'(out_en[2]), 32'h0);
        chk("R2", "sig_out[2] with select 40", 32'(sig_out[2]), 32'h0);
        rd(5'd2, 7'h68, "R2");
        wr(5'd2, 7'h60);
        commit();
        sig_in = '0;
        sig_in[32] = 1'b1;
        #1 chk("R2", "select 32 routes top input", 32'(sig_out[2]), 32'h1);
    endtask

    task automatic t_same_edge();
        logic [6:0] old3;
        old3 = m_stage[3];
        cs_n = 0; we_n = 0; upd_n = 0; addr = 5'd3; wdata = 7'h5F;
        cyc();
        cs_n = 1; we_n = 1; upd_n = 1;
        m_commit();
        m_stage[3] = 7'h5F;
        rd(5'd3, old3, "R5");
        commit();
        rd(5'd3, 7'h5F, "R5");
    endtask

    task automatic t_chip_select();
        logic [6:0] keep;
        keep = rdata;
        cs_n = 1; we_n = 0; upd_n = 0; rd_n = 0; addr = 5'd0; wdata = 7'h41;
        cyc();
        we_n = 1; upd_n = 1; rd_n = 1;
        chk("R7", "rdata unchanged with cs high", 32'(rdata), 32'(keep));
        #1 chk_outs("R7");
        commit();
        rd(5'd0, m_act[0], "R7");
        cs_n = 1; rst_n = 0;
        cyc();
        rst_n = 1;
        m_reset();
        chk("R7", "reset works with cs high", 32'(out_en), 32'h0);
    endtask

    task automatic t_reset_keeps();
        rd(5'd6, m_act[6], "R6");
        wr(5'd5, 7'h4B);
        rst_n = 0; cs_n = 0; upd_n = 0;
        cyc();
        rst_n = 1; cs_n = 1; upd_n = 1;
        m_reset();
        rd(5'd5, m_act[5], "R6");
        commit();
        #1 chk_outs("R6");
        rd(5'd5, 7'h4B, "R6");
    endtask

    initial begin
        cyc();
        t_reset();
        t_load_and_commit();
        t_readback();
        t_bad_addr();
        t_wide_sel();
        t_same_edge();
        t_chip_select();
        t_reset_keeps();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule